// File: doc/BRIEF.md
# Cache Line Fill Sequencer

When a processor read misses in the cache, this block fetches the whole 16-byte line from a 32-bit memory as four longword transfers. It accepts one miss request with its byte address. It then drives the memory address for each transfer in turn, and the transfer order is chosen per fill. In one order the requested longword comes back first. In the other the fetch starts one longword after the requested one and wraps, so the requested word arrives last. A second mode input picks the bus timing: each transfer takes two clocks, or a burst takes two clocks for the first transfer and one clock for each of the others.

Each arriving longword is stored in a line buffer and marked valid. The requested longword is also handed straight to the processor in the clock it arrives. After the fourth transfer the block presents the assembled 128-bit line for one cycle, so the cache array can store it. While a fill is under way, a lookup port lets the processor read any longword of the line that has already landed in the buffer, so such a read counts as a hit.

Top module: `line_fill_seq`

## Requirements
- R1: While reset is held and right after it, `busy`, `mem_req`, `cpu_valid`, `done` and `lk_hit` are all low.
- R2: With `order_first` high and the requested longword index w (address bits [3:2]), the four transfers fetch indices w^0, w^1, w^2, w^3, in that order. `mem_addr` carries the line address in bits [31:4], the index in bits [3:2] and zero in bits [1:0].
- R3: With `order_first` low, the transfers fetch indices (w+1), (w+2), (w+3) and w, each taken modulo 4, so the requested longword is fetched last.
- R4: With `burst_mode` low, each transfer holds `mem_req` and `mem_addr` for two clocks, and `mem_rdata` is taken in the second of them. `busy` is high for 8 cycles.
- R5: With `burst_mode` high, the first transfer lasts two clocks and the others one clock each. `busy` is high for 5 cycles.
- R6: `cpu_valid` is high for exactly one cycle per fill: the cycle in which the requested longword is taken from `mem_rdata`. In that cycle `cpu_data` equals that longword.
- R7: `done` is high for exactly one cycle, the cycle after the fourth longword is taken. In that cycle `busy` is low for the first time, and `line_data` holds longword i at bits [32i+31:32i].
- R8: A miss request made while `busy` is high is ignored. It does not change the transfer sequence of the fill in progress.
- R9: `lk_hit` is high when bits [31:4] of `lk_addr` match the line being filled and the longword selected by bits [3:2] of `lk_addr` has arrived. It becomes high in the cycle after that longword is taken, and `lk_data` then holds that longword. All longwords read as absent from the cycle after a miss is accepted.
- R10: After `done`, the buffered line and its valid marks stay in place, and lookups keep hitting, until the next miss is accepted. That next miss may be accepted in the `done` cycle itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| miss_valid | input | 1 | Read-miss request |
| miss_addr | input | ADDR_W | Byte address of the missed read |
| order_first | input | 1 | 1: requested longword first; 0: requested longword last |
| burst_mode | input | 1 | 1: burst timing 2-1-1-1; 0: 2 clocks per transfer |
| busy | output | 1 | Fill in progress |
| mem_req | output | 1 | Memory transfer active |
| mem_addr | output | ADDR_W | Longword-aligned address of the current transfer |
| mem_rdata | input | 32 | Memory read data |
| cpu_valid | output | 1 | Requested longword is on `cpu_data` |
| cpu_data | output | 32 | Longword forwarded to the processor |
| done | output | 1 | One-cycle line-complete pulse |
| line_data | output | 128 | Assembled line |
| lk_addr | input | ADDR_W | Processor lookup address |
| lk_hit | output | 1 | Lookup longword is valid in the line buffer |
| lk_data | output | 32 | Lookup longword |

## Verification
Two functions can fall in the same cycle. The first case is a lookup aimed at the longword that is arriving in that very cycle: the lookup must still miss, and it must hit one cycle later. The bench drives lookups that sweep the words of the current line every cycle of every fill, with both orders, both timings and all four offsets, so this overlap comes up many times. The second case is a new miss held high through the `done` cycle: it must be accepted right away, while `line_data` still shows the completed line. The bench holds the miss request across `done` for this. In both cases the reference model decides, cycle by cycle, which outcome is correct.

// File: rtl/line_fill_seq.sv
module line_fill_seq #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              order_first,
  input  logic              burst_mode,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [31:0]       mem_rdata,
  output logic              cpu_valid,
  output logic [31:0]       cpu_data,
  output logic              done,
  output logic [127:0]      line_data,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic [31:0]       lk_data
);
  localparam int LW = ADDR_W - 4;

  logic          busy_q, done_q, cnt_q, first_q, burst_q;
  logic [LW-1:0] line_q;
  logic [1:0]    req_off, beat;
  logic [3:0]    vmask;
  logic [31:0]   words [4];
  logic [1:0]    cur_off;
  logic          cap;

  assign cur_off   = first_q ? (req_off ^ beat) : (req_off + 2'd1 + beat);
  assign cap       = busy_q && (cnt_q || (burst_q && beat != 2'd0));
  assign busy      = busy_q;
  assign mem_req   = busy_q;
  assign mem_addr  = {line_q, cur_off, 2'b00};
  assign cpu_valid = cap && (cur_off == req_off);
  assign cpu_data  = mem_rdata;
  assign done      = done_q;
  assign line_data = {words[3], words[2], words[1], words[0]};
  assign lk_hit    = (lk_addr[ADDR_W-1:4] == line_q) && vmask[lk_addr[3:2]];
  assign lk_data   = words[lk_addr[3:2]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= 1'b0;
      first_q <= 1'b0;
      burst_q <= 1'b0;
      line_q  <= '0;
      req_off <= '0;
      beat    <= '0;
      vmask   <= '0;
      for (int i = 0; i < 4; i++) words[i] <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q && miss_valid) begin
        busy_q  <= 1'b1;
        line_q  <= miss_addr[ADDR_W-1:4];
        req_off <= miss_addr[3:2];
        first_q <= order_first;
        burst_q <= burst_mode;
        beat    <= '0;
        cnt_q   <= 1'b0;
        vmask   <= '0;
      end else if (cap) begin
        words[cur_off] <= mem_rdata;
        vmask[cur_off] <= 1'b1;
        cnt_q          <= 1'b0;
        beat           <= beat + 2'd1;
        if (beat == 2'd3) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end else if (busy_q) begin
        cnt_q <= 1'b1;
      end
    end
  end

  a_r6_single_forward: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |=> !cpu_valid);
  a_r6_forward_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_valid |-> busy);
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  a_r8_line_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && miss_valid) |=> $stable(line_q));
  a_r4_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cap) |=> $stable(mem_addr));
  a_r9_mask_only_on_capture: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !cap) |=> $stable(vmask));
endmodule

// File: tb/line_fill_seq_test.sv
module line_fill_seq_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         miss_valid = 1'b0;
  logic [31:0]  miss_addr = '0;
  logic         order_first = 1'b0;
  logic         burst_mode = 1'b0;
  logic         busy, mem_req, cpu_valid, done, lk_hit;
  logic [31:0]  mem_addr, mem_rdata, cpu_data, lk_data;
  logic [31:0]  lk_addr = '0;
  logic [127:0] line_data;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  function automatic logic [31:0] memw(input logic [31:0] a);
    return (a * 32'h9E3779B1) ^ 32'hC3A5_0F1E;
  endfunction

  assign mem_rdata = memw(mem_addr);

  line_fill_seq uut (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .order_first(order_first), .burst_mode(burst_mode), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .cpu_valid(cpu_valid), .cpu_data(cpu_data), .done(done),
    .line_data(line_data), .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_data(lk_data)
  );

  task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                     input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  typedef struct packed {
    logic        busy, req, cv, dn, cap, burst, first;
    logic [1:0]  off;
    logic [31:0] addr, cvd;
  } ent_t;

  ent_t         q[$];
  logic [127:0] exp_line;
  logic [27:0]  m_line = '0;
  logic [3:0]   m_mask = '0;
  bit           mon_on = 0;

  task automatic push_fill(input logic [31:0] a, input bit first, input bit burst);
    logic [1:0] w = a[3:2];
    for (int k = 0; k < 4; k++) begin
      logic [1:0]  off = first ? (w ^ 2'(k)) : 2'(w + 1 + k);
      int          len = (burst && k > 0) ? 1 : 2;
      logic [31:0] ad  = {a[31:4], off, 2'b00};
      exp_line[32*off +: 32] = memw(ad);
      for (int c = 0; c < len; c++) begin
        ent_t e;
        e.busy = 1; e.req = 1; e.dn = 0; e.burst = burst; e.first = first;
        e.off = off; e.addr = ad; e.cap = (c == len - 1);
        e.cv = e.cap && (off == w); e.cvd = memw(ad);
        q.push_back(e);
      end
    end
    begin
      ent_t d;
      d = '0; d.dn = 1; d.burst = burst; d.first = first;
      q.push_back(d);
    end
  endtask

  // reference model compared every cycle, away from the clock edge
  initial begin
    forever begin
      @(negedge clk); #1;
      if (mon_on) begin
        ent_t e;
        bit   hit_exp;
        string tt;
        e = (q.size() > 0) ? q.pop_front() : ent_t'(0);
        tt = e.burst ? "R5 timing" : "R4 timing";
        chk(busy == e.busy, tt, busy, e.busy);
        chk(mem_req == e.req, tt, mem_req, e.req);
        if (e.req) chk(mem_addr == e.addr, e.first ? "R2 order" : "R3 order", mem_addr, e.addr);
        chk(cpu_valid == e.cv, "R6 forward pulse", cpu_valid, e.cv);
        if (e.cv) chk(cpu_data == e.cvd, "R6 forward data", cpu_data, e.cvd);
        chk(done == e.dn, "R7 done", done, e.dn);
        if (e.dn) chk(line_data == exp_line, "R7 line", line_data, exp_line);
        hit_exp = (lk_addr[31:4] == m_line) && m_mask[lk_addr[3:2]];
        chk(lk_hit == hit_exp, (q.size() == 0 && !e.busy) ? "R10 held hit" : "R9 lookup hit",
            lk_hit, hit_exp);
        if (hit_exp) chk(lk_data == memw({lk_addr[31:2], 2'b00}), "R9 lookup data",
                         lk_data, memw({lk_addr[31:2], 2'b00}));
        if (e.cap) m_mask[e.off] = 1'b1;
        if (miss_valid && !e.busy) begin
          m_mask = '0;
          m_line = miss_addr[31:4];
          push_fill(miss_addr, order_first, burst_mode);
        end
      end
    end
  end

  int lkc = 0;
  always @(negedge clk) begin
    lkc++;
    lk_addr = (lkc % 7 == 6) ? {miss_addr[31:4] + 28'd1, 4'h0}
                             : {miss_addr[31:4], 2'(lkc), 2'b00};
  end

  task automatic fill(input logic [31:0] a, input bit first, input bit burst,
                      input bit poke);
    logic [31:0] seen;
    @(negedge clk);
    miss_addr = a; order_first = first; burst_mode = burst; miss_valid = 1;
    @(negedge clk);
    miss_valid = 0;
    if (poke) begin
      @(negedge clk);
      seen = mem_addr;
      miss_addr = a ^ 32'h0001_0040; order_first = !first; miss_valid = 1;
      @(negedge clk);
      miss_valid = 0;
      chk(mem_addr[31:4] == seen[31:4], "R8 miss ignored", mem_addr, seen);
      miss_addr = a;
    end
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req && !cpu_valid && !done && !lk_hit, "R1 reset",
        {busy, mem_req, cpu_valid, done, lk_hit}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !mem_req && !cpu_valid && !done && !lk_hit, "R1 after reset",
        {busy, mem_req, cpu_valid, done, lk_hit}, 0);
    mon_on = 1;
    for (int b = 0; b < 2; b++)
      for (int f = 0; f < 2; f++)
        for (int w = 0; w < 4; w++)
          fill(32'h1234_5600 + 32'(w * 4) + 32'(b * 32'h100) + 32'(f * 32'h40),
               bit'(f), bit'(b), (w == 2));
    // back-to-back: miss held through the done cycle
    @(negedge clk);
    miss_addr = 32'h0ABC_0008; order_first = 1; burst_mode = 1; miss_valid = 1;
    @(negedge clk);
    while (!done) @(negedge clk);
    miss_addr = 32'h0ABC_0134; order_first = 0; burst_mode = 0;
    @(negedge clk);
    miss_valid = 0;
    chk(busy == 1'b1, "R10 accept in done cycle", busy, 1);
    while (busy) @(negedge clk);
    repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule